// File: doc/BRIEF.md
# Byte and Bit-Field Manipulation Unit

A combinational 32-bit datapath for the byte-level and bit-level rearrangement steps of an integer execution stage. A 4-bit operation code selects one function. The source operand, a destination operand, a field start position and a field width arrive with it, and the unit returns one 32-bit result in the same cycle.

The functions fall into four groups. The byte-order group reverses bytes in the whole word, reverses bytes in each halfword, or reverses bytes in the low halfword and then sign-extends. The extend group widens the low byte or the low halfword, with sign fill or zero fill. The field group clears, inserts or extracts a field given by a start bit and a width. The bit-scan group reverses the order of all 32 bits, or counts the leading zeros. A field whose start plus width runs past bit 31 is rejected: the result equals the destination operand and an error output is raised.

Top module: `bfu_top`

## Requirements
- R1: Operation code 0 returns the source with its four bytes in reverse order (byte 0 moves to bits 31:24).
- R2: Operation code 1 swaps the two bytes inside each 16-bit half of the source, each half independently.
- R3: Operation code 2 swaps the two bytes of the low source halfword and sign-extends that 16-bit value to 32 bits.
- R4: Operation code 3 copies source bit 15 into bits 31:16 over the low halfword. Operation code 4 copies source bit 7 into bits 31:8 over the low byte.
- R5: Operation code 5 keeps source bits 15:0 and zeroes bits 31:16. Operation code 6 keeps source bits 7:0 and zeroes bits 31:8.
- R6: Operation code 7 (clear) forces destination bits lsb to lsb+width-1 to zero and keeps all other destination bits.
- R7: Operation code 8 (insert) replaces destination bits lsb to lsb+width-1 with source bits width-1:0 and keeps all other destination bits.
- R8: Operation codes 9 (signed) and 10 (unsigned) move source bits lsb to lsb+width-1 down to bit 0. Above the field the signed form repeats the field's top bit and the unsigned form fills zeros. A width of 0 yields 0.
- R9: Operation code 11 returns the source with bit i moved to bit 31-i.
- R10: Operation code 12 returns the number of zero bits above the highest set source bit, and 32 for an all-zero source.
- R11: For operation codes 7 to 10, a start plus width greater than 32 returns the destination operand unchanged and sets err_o to 1. In all other cases err_o is 0.
- R12: Operation codes 13 to 15 return 0 with err_o at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation select code |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand for clear/insert; returned on a rejected field |
| lsb_i | input | 5 | Field start bit |
| wid_i | input | 6 | Field width, 0 to 63 |
| res_o | output | 32 | Result |
| err_o | output | 1 | Field out of range |

## Verification
The immediate assertions hold whenever the inputs change. They check that a rejected field returns the destination, that a clear never sets a bit, that an unsigned extract leaves no bit above its width, that signed and unsigned extends fill the upper bits correctly, that the leading-zero count stays in range and points at a set bit, and that the error flag is raised only for field operations. Exact bit placement can be shown only by comparing the result with the bench's independent model. This covers the byte orders, the direction of the bit reversal, the inserted value, sign fill at each field position, the boundary where start plus width equals 32, and the codes with no function.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int DATA_W = 32;
  localparam int POS_W  = $clog2(DATA_W);
  localparam int WID_W  = POS_W + 1;

  typedef enum logic [3:0] {
    OP_SWAP_W  = 4'd0,
    OP_SWAP_H  = 4'd1,
    OP_SWAP_HS = 4'd2,
    OP_SEXT_H  = 4'd3,
    OP_SEXT_B  = 4'd4,
    OP_ZEXT_H  = 4'd5,
    OP_ZEXT_B  = 4'd6,
    OP_FCLR    = 4'd7,
    OP_FINS    = 4'd8,
    OP_FEXT_S  = 4'd9,
    OP_FEXT_U  = 4'd10,
    OP_BREV    = 4'd11,
    OP_LZC     = 4'd12
  } bfu_op_e;
endpackage

// File: rtl/bfu_bytes.sv
module bfu_bytes
  import bfu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  bfu_op_e         op_i,
  input  logic [DW-1:0]   src_i,
  output logic [DW-1:0]   res_o
);
  localparam int NB = DW / 8;

  logic [DW-1:0] swap_w, swap_h, brev;

  for (genvar g = 0; g < NB; g++) begin : g_word
    assign swap_w[g*8 +: 8] = src_i[(NB-1-g)*8 +: 8];
  end

  for (genvar h = 0; h < NB/2; h++) begin : g_half
    assign swap_h[h*16 +: 8]     = src_i[h*16 + 8 +: 8];
    assign swap_h[h*16 + 8 +: 8] = src_i[h*16 +: 8];
  end

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign brev[b] = src_i[DW-1-b];
  end

  always_comb begin
    unique case (op_i)
      OP_SWAP_W:  res_o = swap_w;
      OP_SWAP_H:  res_o = swap_h;
      OP_SWAP_HS: res_o = {{(DW-16){swap_h[15]}}, swap_h[15:0]};
      OP_SEXT_H:  res_o = {{(DW-16){src_i[15]}}, src_i[15:0]};
      OP_SEXT_B:  res_o = {{(DW-8){src_i[7]}}, src_i[7:0]};
      OP_ZEXT_H:  res_o = {{(DW-16){1'b0}}, src_i[15:0]};
      OP_ZEXT_B:  res_o = {{(DW-8){1'b0}}, src_i[7:0]};
      OP_BREV:    res_o = brev;
      default:    res_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == OP_SEXT_B)
      assert_sext_fill_R4: assert (res_o[DW-1:8] == {(DW-8){src_i[7]}});
    if (op_i == OP_ZEXT_H)
      assert_zext_top_R5: assert (res_o[DW-1:16] == '0 && res_o[15:0] == src_i[15:0]);
  end
endmodule

// File: rtl/bfu_field.sv
module bfu_field
  import bfu_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int PW = $clog2(DW),
  localparam int WW = PW + 1
) (
  input  bfu_op_e         op_i,
  input  logic [DW-1:0]   src_i,
  input  logic [DW-1:0]   dst_i,
  input  logic [PW-1:0]   lsb_i,
  input  logic [WW-1:0]   wid_i,
  output logic [DW-1:0]   res_o,
  output logic            bad_o
);
  logic [WW:0]     span;
  logic            ok;
  logic [2*DW-1:0] wide;
  logic [DW-1:0]   low_mask, fmask, shr, fld;
  logic [PW-1:0]   top_idx;
  logic            sgn;

  always_comb begin
    span     = {1'b0, wid_i} + {{(WW+1-PW){1'b0}}, lsb_i};
    ok       = (span <= (WW+1)'(DW));
    wide     = ((2*DW)'(1) << wid_i) - (2*DW)'(1);
    low_mask = wide[DW-1:0];
    fmask    = low_mask << lsb_i;
    shr      = src_i >> lsb_i;
    fld      = shr & low_mask;
    top_idx  = PW'(wid_i - WW'(1));
    sgn      = (wid_i != '0) && shr[top_idx];
    unique case (op_i)
      OP_FCLR:   res_o = dst_i & ~fmask;
      OP_FINS:   res_o = (dst_i & ~fmask) | ((src_i << lsb_i) & fmask);
      OP_FEXT_S: res_o = sgn ? (fld | ~low_mask) : fld;
      OP_FEXT_U: res_o = fld;
      default:   res_o = dst_i;
    endcase
    if (!ok) res_o = dst_i;
    bad_o = !ok;
  end

  always_comb begin
    if (bad_o)
      assert_invalid_keeps_dst_R11: assert (res_o == dst_i);
    if (op_i == OP_FCLR)
      assert_clear_no_set_R6: assert ((res_o & ~dst_i) == '0);
    if (op_i == OP_FEXT_U && !bad_o && wid_i < WW'(DW))
      assert_uext_no_high_R8: assert ((res_o >> wid_i) == '0);
  end
endmodule

// File: rtl/bfu_lzc.sv
module bfu_lzc #(
  parameter int DW = 32,
  localparam int CW = $clog2(DW) + 1
) (
  input  logic [DW-1:0] src_i,
  output logic [CW-1:0] cnt_o
);
  logic found;

  always_comb begin
    cnt_o = CW'(DW);
    found = 1'b0;
    for (int i = DW-1; i >= 0; i--) begin
      if (!found && src_i[i]) begin
        cnt_o = CW'(DW-1-i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    assert_lzc_range_R10: assert (cnt_o <= CW'(DW));
    if (src_i != '0)
      assert_lzc_hits_one_R10: assert (src_i[DW-1-int'(cnt_o)]);
  end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter int DW = DATA_W,
  localparam int PW = $clog2(DW),
  localparam int WW = PW + 1,
  localparam int CW = PW + 1
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  input  logic [PW-1:0] lsb_i,
  input  logic [WW-1:0] wid_i,
  output logic [DW-1:0] res_o,
  output logic          err_o
);
  bfu_op_e       op;
  logic [DW-1:0] byte_res, fld_res;
  logic          fld_bad, is_fld;
  logic [CW-1:0] lz_cnt;

  assign op = bfu_op_e'(op_i);

  bfu_bytes #(.DW(DW)) u_bytes (.op_i(op), .src_i(src_i), .res_o(byte_res));

  bfu_field #(.DW(DW)) u_field (
    .op_i(op), .src_i(src_i), .dst_i(dst_i), .lsb_i(lsb_i), .wid_i(wid_i),
    .res_o(fld_res), .bad_o(fld_bad)
  );

  bfu_lzc #(.DW(DW)) u_lzc (.src_i(src_i), .cnt_o(lz_cnt));

  always_comb begin
    is_fld = (op_i >= 4'(OP_FCLR)) && (op_i <= 4'(OP_FEXT_U));
    err_o  = is_fld && fld_bad;
    if (is_fld)             res_o = fld_res;
    else if (op == OP_LZC)  res_o = {{(DW-CW){1'b0}}, lz_cnt};
    else                    res_o = byte_res;
  end

  always_comb begin
    if (err_o)
      assert_err_field_only_R11: assert (op_i >= 4'd7 && op_i <= 4'd10);
    if (op_i > 4'd12)
      assert_unused_zero_R12: assert (res_o == '0 && !err_o);
  end
endmodule

// File: tb/sim_bfu_top.sv
module sim_bfu_top;
  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] src;
    logic [31:0] dst;
    logic [4:0]  lsb;
    logic [5:0]  wid;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  32'h11223344, 32'h0,        5'd0,  6'd0,  32'h44332211, 1'b0}, // R1
    '{4'd1,  32'h11223344, 32'h0,        5'd0,  6'd0,  32'h22114433, 1'b0}, // R2
    '{4'd2,  32'h000012F4, 32'h0,        5'd0,  6'd0,  32'hFFFFF412, 1'b0}, // R3
    '{4'd2,  32'hAB347F12, 32'h0,        5'd0,  6'd0,  32'h0000127F, 1'b0}, // R3
    '{4'd3,  32'h12348000, 32'h0,        5'd0,  6'd0,  32'hFFFF8000, 1'b0}, // R4
    '{4'd4,  32'h0000017F, 32'h0,        5'd0,  6'd0,  32'h0000007F, 1'b0}, // R4
    '{4'd4,  32'h00000080, 32'h0,        5'd0,  6'd0,  32'hFFFFFF80, 1'b0}, // R4
    '{4'd5,  32'hFFFF8001, 32'h0,        5'd0,  6'd0,  32'h00008001, 1'b0}, // R5
    '{4'd6,  32'hFFFFFF80, 32'h0,        5'd0,  6'd0,  32'h00000080, 1'b0}, // R5
    '{4'd7,  32'h0,        32'hFFFFFFFF, 5'd4,  6'd8,  32'hFFFFF00F, 1'b0}, // R6
    '{4'd7,  32'h0,        32'h5A5A5A5A, 5'd31, 6'd0,  32'h5A5A5A5A, 1'b0}, // R6
    '{4'd8,  32'h000000AB, 32'h00000000, 5'd8,  6'd8,  32'h0000AB00, 1'b0}, // R7
    '{4'd8,  32'h00000000, 32'hFFFFFFFF, 5'd28, 6'd4,  32'h0FFFFFFF, 1'b0}, // R7
    '{4'd8,  32'hFFFFFFFF, 32'h12345678, 5'd30, 6'd4,  32'h12345678, 1'b1}, // R11
    '{4'd9,  32'h0000F000, 32'h0,        5'd12, 6'd4,  32'hFFFFFFFF, 1'b0}, // R8
    '{4'd10, 32'h0000F000, 32'h0,        5'd12, 6'd4,  32'h0000000F, 1'b0}, // R8
    '{4'd9,  32'h00007000, 32'h0,        5'd12, 6'd4,  32'h00000007, 1'b0}, // R8
    '{4'd9,  32'h80000000, 32'h0,        5'd0,  6'd32, 32'h80000000, 1'b0}, // R8
    '{4'd10, 32'h80000000, 32'h0,        5'd0,  6'd32, 32'h80000000, 1'b0}, // R8
    '{4'd10, 32'hFFFFFFFF, 32'h00C0FFEE, 5'd1,  6'd32, 32'h00C0FFEE, 1'b1}, // R11
    '{4'd11, 32'h00000001, 32'h0,        5'd0,  6'd0,  32'h80000000, 1'b0}, // R9
    '{4'd11, 32'h12345678, 32'h0,        5'd0,  6'd0,  32'h1E6A2C48, 1'b0}, // R9
    '{4'd12, 32'h00000000, 32'h0,        5'd0,  6'd0,  32'd32,       1'b0}, // R10
    '{4'd12, 32'h00000001, 32'h0,        5'd0,  6'd0,  32'd31,       1'b0}, // R10
    '{4'd12, 32'h80000000, 32'h0,        5'd0,  6'd0,  32'd0,        1'b0}, // R10
    '{4'd12, 32'h00F00000, 32'h0,        5'd0,  6'd0,  32'd8,        1'b0}, // R10
    '{4'd13, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0,  6'd0,  32'h0,        1'b0}, // R12
    '{4'd15, 32'h12345678, 32'h87654321, 5'd31, 6'd40, 32'h0,        1'b0}  // R12
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i;
  logic [31:0] src_i, dst_i, res_o;
  logic [4:0]  lsb_i;
  logic [5:0]  wid_i;
  logic        err_o;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  bfu_top u0 (.op_i, .src_i, .dst_i, .lsb_i, .wid_i, .res_o, .err_o);

  function automatic logic [32:0] model(logic [3:0] op, logic [31:0] s, logic [31:0] d,
                                        int lsb, int wid);
    logic [31:0] r = '0;
    bit bad = (lsb + wid > 32);
    case (op)
      0: r = {s[7:0], s[15:8], s[23:16], s[31:24]};
      1: r = {s[23:16], s[31:24], s[7:0], s[15:8]};
      2: r = {{16{s[7]}}, s[7:0], s[15:8]};
      3: r = {{16{s[15]}}, s[15:0]};
      4: r = {{24{s[7]}}, s[7:0]};
      5: r = {16'h0, s[15:0]};
      6: r = {24'h0, s[7:0]};
      7, 8: begin
        r = d;
        for (int i = lsb; i < lsb + wid && i < 32; i++) r[i] = (op == 8) ? s[i-lsb] : 1'b0;
      end
      9, 10: begin
        for (int i = 0; i < wid && lsb + i < 32; i++) r[i] = s[lsb+i];
        if (op == 9 && wid > 0 && !bad)
          for (int i = wid; i < 32; i++) r[i] = s[lsb+wid-1];
      end
      11: for (int i = 0; i < 32; i++) r[31-i] = s[i];
      12: begin
        int n = 0;
        while (n < 32 && !s[31-n]) n++;
        r = 32'(n);
      end
      default: r = '0;
    endcase
    if (op >= 7 && op <= 10 && bad) r = d;
    return {(op >= 7 && op <= 10 && bad), r};
  endfunction

  task automatic apply(logic [3:0] op, logic [31:0] s, logic [31:0] d,
                       logic [4:0] l, logic [5:0] w, logic [31:0] er, logic ee,
                       string tag);
    @(posedge clk);
    op_i = op; src_i = s; dst_i = d; lsb_i = l; wid_i = w;
    @(negedge clk);
    checks++;
    if (res_o !== er || err_o !== ee) begin
      errors++;
      $display("FAIL %s op=%0d res=%h err=%b expected res=%h err=%b", tag, op, res_o, err_o, er, ee);
    end
  endtask

  initial begin
    logic [32:0] m;
    op_i = 4'd14; src_i = 32'hDEADBEEF; dst_i = '0; lsb_i = '0; wid_i = '0;
    repeat (3) @(posedge clk);
    // R12: idle code after reset gives zero, no error
    @(negedge clk);
    checks++;
    if (res_o !== 32'h0 || err_o !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset idle res=%h err=%b expected res=00000000 err=0", res_o, err_o);
    end
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++)
      apply(VEC[k].op, VEC[k].src, VEC[k].dst, VEC[k].lsb, VEC[k].wid,
            VEC[k].exp, VEC[k].err, "R1..R12 vector");

    // R6 R7 R8 R11: whole-word boundary and one-past boundary
    apply(4'd8, 32'hCAFEF00D, 32'h0, 5'd0, 6'd32, 32'hCAFEF00D, 1'b0, "R7 full word");
    apply(4'd7, 32'h0, 32'hFFFFFFFF, 5'd0, 6'd33, 32'hFFFFFFFF, 1'b1, "R11 width 33");
    apply(4'd9, 32'h80000000, 32'h0, 5'd31, 6'd1, 32'hFFFFFFFF, 1'b0, "R8 top bit");
    apply(4'd9, 32'hFFFFFFFF, 32'h0, 5'd5, 6'd0, 32'h0, 1'b0, "R8 zero width");

    // random sweep over all codes, fields sometimes out of range
    for (int k = 0; k < 2000; k++) begin
      logic [3:0]  op = 4'($urandom_range(0, 15));
      logic [31:0] s  = $urandom;
      logic [31:0] d  = $urandom;
      logic [4:0]  l  = 5'($urandom_range(0, 31));
      logic [5:0]  w  = 6'($urandom_range(0, 40));
      if (k % 4 == 0) s = s >> $urandom_range(0, 31);
      m = model(op, s, d, int'(l), int'(w));
      apply(op, s, d, l, w, m[31:0], m[32], "R1..R12 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule